// File: doc/BRIEF.md
# Instruction-Driven Pattern Sequencer

This block steps through a program held in an external synchronous instruction memory and drives a 64-bit word of digital output channels. Each 128-bit instruction carries three things: the channel word to apply, an opcode that picks the next address, and a hold time in clock cycles that sets how long the instruction stays in force. The opcodes cover plain advance, stop, one counted loop, a single-level subroutine call and return, an unconditional jump, a hold stretched by a multiplier, and a pause until an external trigger edge. Opcode values 9 to 15 behave as plain advance.

A host loads the memory and then pulses `start_i`. The sequencer reads address 0 and follows the program until it decodes a stop. The current read address is always visible on `mem_addr_o`, so that a refill controller can tell which region of memory is in use. The trigger input may be asynchronous to the sequencer clock.

Top module: `pat_seq`

## Requirements
- R1: While reset is asserted and afterwards until a start, `chan_o` is 0, `done_o` is 0 and `mem_addr_o` is 0.
- R2: Instruction layout: channel word in bits [63:0], opcode in [67:64], argument in [87:68], hold count in [119:88]. Bits [127:120] have no effect.
- R3: Counting the edge that samples `start_i` as edge 0, the channel word of the instruction at address 0 appears on `chan_o` after edge 2. An instruction with hold count D keeps its word for D+2 cycles before the next word appears, so D = 0 gives 2 cycles.
- R4: LOOP (opcode 2) loads an iteration count N ≥ 1. END LOOP (opcode 3) jumps to its argument address while the remaining count, after it is decremented, is non-zero, and otherwise falls through. The loop body therefore runs N times.
- R5: CALL (opcode 4) records the address after itself and jumps to its argument address. RETURN (opcode 5) resumes at the recorded address. There is only one level.
- R6: JUMP (opcode 6) continues at its argument. Argument bits above the address width are ignored.
- R7: LONG DELAY (opcode 7) holds its word for D×M+2 cycles, where D is the hold count and M is the argument.
- R8: WAIT (opcode 8) applies its word and ignores its hold count. It advances only on a rising trigger edge that the two-stage synchroniser detects after WAIT was entered. A trigger that is already high when WAIT is entered does not count.
- R9: STOP (opcode 1) raises `done_o` and leaves `chan_o` and `mem_addr_o` unchanged from then on. The stop instruction's channel word is not applied.
- R10: `start_i` is accepted only when idle or done. It clears `done_o` and restarts at address 0. While the program is running, `start_i` is ignored.
- R11: `mem_addr_o` shows the address being fetched. While waiting or stopped, it rests on the address after WAIT or on the STOP address, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin execution at address 0 |
| trig_i | input | 1 | External trigger, may be asynchronous |
| mem_rdata_i | input | 128 | Instruction word, valid one cycle after the address |
| mem_addr_o | output | ADDR_W | Instruction memory read address |
| chan_o | output | 64 | Output channel word |
| done_o | output | 1 | Program reached STOP |

## Verification
The bench builds the block with `ADDR_W` = 6 and `SYNC_STAGES` = 2. A 64-word model memory then holds a program that uses every opcode, and a jump argument with bit 6 set checks that argument bits above the address width are dropped. The short hold counts and a multiplier of 3 put exact cycle-by-cycle timing of loops, the call/return pair and the stretched hold within a few dozen cycles. The trigger is held high across the entry into WAIT, so that only a later fresh edge releases it.

// File: rtl/pat_seq_pkg.sv
package pat_seq_pkg;
   localparam int INSN_W   = 128;
   localparam int CHAN_W   = 64;
   localparam int OP_W     = 4;
   localparam int ARG_W    = 20;
   localparam int DLY_W    = 32;
   localparam int FLAG_LSB = 0;
   localparam int OP_LSB   = FLAG_LSB + CHAN_W;
   localparam int ARG_LSB  = OP_LSB + OP_W;
   localparam int DLY_LSB  = ARG_LSB + ARG_W;
   localparam int RSV_LSB  = DLY_LSB + DLY_W;

   typedef enum logic [OP_W-1:0] {
      OP_NEXT = 4'd0,
      OP_STOP = 4'd1,
      OP_LOOP = 4'd2,
      OP_ENDL = 4'd3,
      OP_CALL = 4'd4,
      OP_RET  = 4'd5,
      OP_JUMP = 4'd6,
      OP_LONG = 4'd7,
      OP_WAIT = 4'd8
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_DEC,
      ST_HOLD,
      ST_WAIT,
      ST_DONE
   } st_e;

   typedef struct packed {
      logic [DLY_W-1:0]  dly;
      logic [ARG_W-1:0]  arg;
      logic [OP_W-1:0]   op;
      logic [CHAN_W-1:0] flags;
   } insn_t;
endpackage

// File: rtl/pat_seq_sync.sv
module pat_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pat_seq_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pat_seq_timer.sv
module pat_seq_timer #(
   parameter int DLY_W = 32,
   parameter int REP_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DLY_W-1:0] dly_i,
   input  logic [REP_W-1:0] reps_i,
   output logic             last_o
);
   logic [DLY_W-1:0] inner_q;
   logic [DLY_W-1:0] reload_q;
   logic [REP_W-1:0] outer_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inner_q  <= '0;
         reload_q <= '0;
         outer_q  <= '0;
      end else if (load_i) begin
         inner_q  <= dly_i;
         reload_q <= dly_i;
         outer_q  <= reps_i;
      end else if (inner_q != '0) begin
         if (inner_q == DLY_W'(1)) begin
            if (outer_q > REP_W'(1)) begin
               outer_q <= outer_q - 1'b1;
               inner_q <= reload_q;
            end else begin
               inner_q <= '0;
            end
         end else begin
            inner_q <= inner_q - 1'b1;
         end
      end
   end

   assign last_o = (inner_q == DLY_W'(1)) && (outer_q <= REP_W'(1));
endmodule

// File: rtl/pat_seq_flow.sv
module pat_seq_flow
   import pat_seq_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              step_i,
   input  op_e               op_i,
   input  logic [ARG_W-1:0]  arg_i,
   input  logic [ADDR_W-1:0] pc_i,
   output logic [ADDR_W-1:0] next_pc_o
);
   logic [ARG_W-1:0]  loop_q;
   logic [ADDR_W-1:0] ret_q;
   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] tgt_pc;
   logic              again;
   logic              unused_arg;

   assign seq_pc     = ADDR_W'(pc_i + 1'b1);
   assign tgt_pc     = arg_i[ADDR_W-1:0];
   assign again      = loop_q > ARG_W'(1);
   assign unused_arg = ^arg_i;

   always_comb begin
      case (op_i)
         OP_STOP:          next_pc_o = pc_i;
         OP_ENDL:          next_pc_o = again ? tgt_pc : seq_pc;
         OP_CALL, OP_JUMP: next_pc_o = tgt_pc;
         OP_RET:           next_pc_o = ret_q;
         default:          next_pc_o = seq_pc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         loop_q <= '0;
         ret_q  <= '0;
      end else if (step_i) begin
         case (op_i)
            OP_LOOP: loop_q <= arg_i;
            OP_ENDL: loop_q <= again ? loop_q - 1'b1 : '0;
            OP_CALL: ret_q  <= seq_pc;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pat_seq.sv
module pat_seq
   import pat_seq_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              trig_i,
   input  logic [INSN_W-1:0] mem_rdata_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [CHAN_W-1:0] chan_o,
   output logic              done_o
);
   generate
      if (ADDR_W < 1 || ADDR_W > ARG_W) begin : g_bad_addr
         $error("pat_seq: ADDR_W must lie in 1..ARG_W");
      end
   endgenerate

   st_e               state_q;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] next_pc;
   insn_t             insn;
   op_e               op;
   logic              trig_rise;
   logic              tmr_last;
   logic              accept;
   logic              in_dec;
   logic              hold_nz;
   logic [ARG_W-1:0]  reps;
   logic              unused_rsv;

   assign insn       = insn_t'(mem_rdata_i[RSV_LSB-1:0]);
   assign unused_rsv = ^mem_rdata_i[INSN_W-1:RSV_LSB];
   assign op         = op_e'(insn.op);
   assign in_dec     = (state_q == ST_DEC);
   assign accept     = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
   assign reps       = (op == OP_LONG) ? insn.arg : ARG_W'(1);
   assign hold_nz    = (insn.dly != '0) && (reps != '0);

   pat_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (trig_i),
      .rise_o (trig_rise)
   );

   pat_seq_timer #(.DLY_W(DLY_W), .REP_W(ARG_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (in_dec),
      .dly_i  (insn.dly),
      .reps_i (reps),
      .last_o (tmr_last)
   );

   pat_seq_flow #(.ADDR_W(ADDR_W)) u_flow (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (accept),
      .step_i    (in_dec),
      .op_i      (op),
      .arg_i     (insn.arg),
      .pc_i      (pc_q),
      .next_pc_o (next_pc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         chan_o  <= '0;
         done_o  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE, ST_DONE: begin
               if (start_i) begin
                  pc_q    <= '0;
                  done_o  <= 1'b0;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: state_q <= ST_DEC;
            ST_DEC: begin
               if (op == OP_STOP) begin
                  done_o  <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  chan_o <= insn.flags;
                  pc_q   <= next_pc;
                  if (op == OP_WAIT)
                     state_q <= ST_WAIT;
                  else
                     state_q <= hold_nz ? ST_HOLD : ST_FETCH;
               end
            end
            ST_HOLD: if (tmr_last) state_q <= ST_FETCH;
            ST_WAIT: if (trig_rise) state_q <= ST_FETCH;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_addr_o = pc_q;
endmodule

// File: rtl/pat_seq_chk.sv
module pat_seq_chk
   import pat_seq_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [CHAN_W-1:0] chan_o,
   input logic              done_o,
   input st_e               state_q
);
   AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> done_o && $stable(chan_o) && $stable(mem_addr_o)); // R9
   AST_DONE_FROM_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(state_q) == ST_DEC); // R9
   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && start_i |=> !done_o && mem_addr_o == '0); // R10
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_WAIT && start_i |=> $stable(mem_addr_o)); // R10
   AST_CHAN_ON_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(chan_o) |-> $past(state_q) == ST_DEC); // R3
endmodule

bind pat_seq pat_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .mem_addr_o (mem_addr_o),
   .chan_o     (chan_o),
   .done_o     (done_o),
   .state_q    (state_q)
);

// File: tb/sim_pat_seq.sv
module sim_pat_seq;
   localparam int AW = 6;
   localparam int NEV = 14;
   // expected channel events: edge index after start edge, word index, requirement
   localparam int EV_T [NEV] = '{2, 7, 9, 12, 14, 17, 19, 22, 24, 26, 28, 30, 38, 40};
   localparam int EV_K [NEV] = '{1, 2, 3, 4, 3, 4, 3, 4, 5, 8, 9, 6, 7, 10};
   // R2 R3 first two, R4 loop rows, R5 call rows, R7 long rows, R6 jump lands on 12
   localparam int EV_R [NEV] = '{2, 3, 4, 4, 4, 4, 4, 4, 5, 5, 5, 7, 7, 6};

   logic          clk = 0;
   logic          rst_n = 0;
   logic          start = 0;
   logic          trig = 0;
   logic [127:0]  rdata;
   logic [AW-1:0] addr;
   logic [63:0]   chan;
   logic          done;
   logic [127:0]  mem [64];
   int            n_run = 0;
   int            n_fail = 0;
   int            t = 0;
   bit            finished = 0;

   always #5 clk = ~clk;

   pat_seq #(.ADDR_W(AW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .trig_i(trig),
      .mem_rdata_i(rdata), .mem_addr_o(addr), .chan_o(chan), .done_o(done)
   );

   always_ff @(posedge clk) rdata <= mem[addr];

   function automatic logic [63:0] fl(input int k);
      return 64'h1111_1111_1111_1111 * 64'(k);
   endfunction

   function automatic logic [127:0] ins(input int op, input int arg, input int dly,
                                        input int k, input int rsv);
      return {8'(rsv), 32'(dly), 20'(arg), 4'(op), fl(k)};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic report;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   task automatic pulse_start;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      t = 0;
   endtask

   task automatic adv(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         t++;
      end
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog act=hung exp=finished");
         report();
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = ins(1, 0, 0, 15, 0);
      mem[0]  = ins(0, 0, 3, 1, 8'hFF);   // R2 reserved bits set
      mem[1]  = ins(2, 3, 0, 2, 0);       // R4 loop of 3
      mem[2]  = ins(0, 0, 1, 3, 0);
      mem[3]  = ins(3, 2, 0, 4, 0);
      mem[4]  = ins(4, 10, 0, 5, 0);      // R5 call
      mem[5]  = ins(7, 3, 2, 6, 0);       // R7 2x3
      mem[6]  = ins(6, 'h4C, 0, 7, 0);    // R6 jump, bit 6 dropped
      mem[10] = ins(0, 0, 0, 8, 0);
      mem[11] = ins(5, 0, 0, 9, 0);
      mem[12] = ins(8, 0, 5, 10, 0);      // R8 wait
      mem[13] = ins(1, 0, 0, 15, 0);      // R9 stop

      repeat (3) @(negedge clk);
      chk("R1 chan in reset", chan, 64'h0);
      chk("R1 done in reset", 64'(done), 64'h0);
      rst_n = 1;
      trig = 1;                            // R8 high before WAIT is entered
      adv(4);
      chk("R1 idle addr", 64'(addr), 64'h0);
      chk("R1 idle chan", chan, 64'h0);

      pulse_start();
      for (int i = 0; i < NEV; i++) begin
         adv(EV_T[i] - 1 - t);
         chk($sformatf("R%0d before ev%0d", (i == 0) ? 3 : EV_R[i], i), chan,
             (i == 0) ? 64'h0 : fl(EV_K[i-1]));
         adv(1);
         chk($sformatf("R%0d at ev%0d", EV_R[i], i), chan, fl(EV_K[i]));
      end

      adv(20);
      chk("R8 still waiting chan", chan, fl(10));
      chk("R8 not done", 64'(done), 64'h0);
      chk("R11 wait addr", 64'(addr), 64'd13);
      pulse_start();                       // R10 ignored while running
      adv(3);
      chk("R10 start ignored addr", 64'(addr), 64'd13);
      chk("R10 start ignored chan", chan, fl(10));

      @(negedge clk) trig = 0;
      adv(4);
      chk("R8 no edge yet", 64'(done), 64'h0);
      @(negedge clk) trig = 1;
      adv(8);
      chk("R9 done high", 64'(done), 64'h1);
      chk("R9 chan frozen", chan, fl(10));
      chk("R9 R11 stop addr", 64'(addr), 64'd13);
      adv(5);
      chk("R9 still frozen", chan, fl(10));

      pulse_start();
      chk("R10 done cleared", 64'(done), 64'h0);
      chk("R10 addr zero", 64'(addr), 64'h0);
      adv(2);
      chk("R10 restart word", chan, fl(1));

      @(negedge clk) rst_n = 0;
      @(negedge clk);
      chk("R1 reset mid run", chan, 64'h0);
      chk("R1 reset done", 64'(done), 64'h0);

      finished = 1;
      report();
   end
endmodule